// File: doc/BRIEF.md
# Asynchronous Host Register Port with Mailbox Flags

This block connects an external microcontroller to the fabric through a bare, unclocked parallel bus. The host provides a 4-bit register address, an active-low read strobe and an active-low write strobe, and shares a 16-bit bidirectional data bus. Every exchange between the two sides goes through this register space. The block brings the strobes, address and data into the fabric clock domain, runs a small state machine that classifies each bus access, produces a one-cycle register write toward the fabric, and returns read data onto the shared bus.

One address holds a flag word that belongs to the block. Its low byte holds mailbox bits. Fabric logic sets a mailbox bit with a request pulse. The host acknowledges it by writing a one to that bit position. Seven fabric status inputs sit in the middle of the word. The top bit is a sticky error that records an access in which both strobes were asserted together.

The state machine has four states. `ST_IDLE` waits for an access. `ST_READ` drives the bus. `ST_WRITE` tracks an active write. `ST_CLASH` is entered when both strobes are seen together. Its transitions are:
- IDLE→READ on read only.
- IDLE→WRITE on write only.
- IDLE→CLASH on both strobes.
- READ→IDLE when the read strobe is released.
- READ→CLASH if the write strobe appears during a read.
- WRITE→IDLE when the write strobe is released; this transition commits the write.
- WRITE→CLASH if the read strobe appears during a write.
- CLASH→IDLE once both strobes are released.

Top module: `mcu_regport`

## Requirements
- R1: After reset the data bus is released, the mailbox bits and the error bit are 0, and no register write is issued.
- R2: A host write to any address other than the flag address produces exactly one cycle of `reg_wr_en`. It carries the address and data present while the write strobe was last seen low, and it is issued after the strobe's release is seen through the two-flop synchronizer.
- R3: A host read of a non-flag address returns on the bus the value that the fabric presents on `reg_rd_data` for that address, which the block requests on `reg_rd_addr`.
- R4: The block drives the data bus only while a read access is in progress, and releases it to high impedance otherwise, including during a clash.
- R5: The flag word is at address 15. Bits 7:0 are the mailbox bits, bits 14:8 mirror `sts_in`, and bit 15 is the clash error.
- R6: A one-cycle pulse on a bit of `mbx_set` sets the matching mailbox bit. The bit is visible both on `mbx_flags` and in the flag word.
- R7: Writing the flag word clears exactly those mailbox bits written as 1 (write-one-to-clear). Bits written as 0 keep their value, and no fabric request is needed to keep them.
- R8: When a fabric set request and a host clear reach the same mailbox bit in the same cycle, the bit ends up set.
- R9: An access in which both strobes are asserted together writes nothing and sets the error bit (flag bit 15, also on `proto_err`). The error bit stays set until the host writes the flag word with bit 15 set to 1.
- R10: Writes to the flag address never produce `reg_wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 4 | Register address from the host |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low |
| host_data | inout | 16 | Shared data bus |
| mbx_set | input | 8 | Fabric request pulses that set mailbox bits |
| sts_in | input | 7 | Fabric status bits shown in the flag word |
| mbx_flags | output | 8 | Current mailbox bits |
| proto_err | output | 1 | Sticky clash error |
| reg_rd_addr | output | 4 | Address whose contents the block is reading |
| reg_rd_data | input | 16 | Fabric register contents for `reg_rd_addr` |
| reg_wr_en | output | 1 | One-cycle write strobe toward the fabric |
| reg_wr_addr | output | 4 | Write address |
| reg_wr_data | output | 16 | Write data |

## Verification
The bench writes and then reads back every non-flag address, and it checks that each write yields exactly one fabric write pulse. A block that sampled data after the strobe was released would return wrong values, and a block that committed on every cycle of the strobe would overcount the pulses. Each mailbox bit is set and cleared in turn, and a mixed mask checks that bits written as 0 survive. A set request is also timed to arrive in the same cycle as a clear, where a block that gave the clear priority would lose the bit. A clash access is checked for three things: the bus stays released, the target register is left untouched, and the error holds until it is explicitly cleared.

// File: rtl/mcu_regport_pkg.sv
package mcu_regport_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_CLASH = 2'd3
    } port_state_t;
endpackage

// File: rtl/mrp_sync.sv
module mrp_sync #(
    parameter int AW     = 4,
    parameter int DW     = 16,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_n_raw,
    input  logic          wr_n_raw,
    input  logic [AW-1:0] addr_raw,
    input  logic [DW-1:0] data_raw,
    output logic          rd_act,
    output logic          wr_act,
    output logic [AW-1:0] addr_s,
    output logic [DW-1:0] data_s
);
    localparam int PW = 2 + AW + DW;
    localparam logic [PW-1:0] PRST = {2'b11, {(PW-2){1'b0}}};

    logic [PW-1:0] stg [STAGES];
    logic          rd_n_s;
    logic          wr_n_s;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= PRST;
                else        stg[g] <= {rd_n_raw, wr_n_raw, addr_raw, data_raw};
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= PRST;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign {rd_n_s, wr_n_s, addr_s, data_s} = stg[STAGES-1];
    assign rd_act = !rd_n_s;
    assign wr_act = !wr_n_s;
endmodule

// File: rtl/mrp_fsm.sv
module mrp_fsm
    import mcu_regport_pkg::*;
#(
    parameter int          AW        = 4,
    parameter int          DW        = 16,
    parameter logic [AW-1:0] FLAG_ADDR = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_act,
    input  logic          wr_act,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] data_s,
    input  logic [DW-1:0] flag_word,
    input  logic [DW-1:0] reg_rd_data,
    output logic [AW-1:0] reg_rd_addr,
    output logic          drive_en,
    output logic [DW-1:0] drive_data,
    output logic          reg_wr_en,
    output logic          flag_wr,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          clash_pulse
);
    port_state_t   state, nxt;
    logic [AW-1:0] cap_addr;
    logic [DW-1:0] cap_data;
    logic          commit;

    assign reg_rd_addr = addr_s;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (rd_act && wr_act) nxt = ST_CLASH;
                else if (rd_act)      nxt = ST_READ;
                else if (wr_act)      nxt = ST_WRITE;
            end
            ST_READ: begin
                if (wr_act)       nxt = ST_CLASH;
                else if (!rd_act) nxt = ST_IDLE;
            end
            ST_WRITE: begin
                if (rd_act)       nxt = ST_CLASH;
                else if (!wr_act) nxt = ST_IDLE;
            end
            ST_CLASH: begin
                if (!rd_act && !wr_act) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign commit = (state == ST_WRITE) && (nxt == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_en    <= 1'b0;
            drive_data  <= '0;
            reg_wr_en   <= 1'b0;
            flag_wr     <= 1'b0;
            wr_addr     <= '0;
            wr_data     <= '0;
            cap_addr    <= '0;
            cap_data    <= '0;
            clash_pulse <= 1'b0;
        end else begin
            drive_en    <= (nxt == ST_READ);
            clash_pulse <= (state != ST_CLASH) && (nxt == ST_CLASH);
            if (state == ST_IDLE && nxt == ST_READ)
                drive_data <= (addr_s == FLAG_ADDR) ? flag_word : reg_rd_data;
            if (wr_act && !rd_act) begin
                cap_addr <= addr_s;
                cap_data <= data_s;
            end
            reg_wr_en <= commit && (cap_addr != FLAG_ADDR);
            flag_wr   <= commit && (cap_addr == FLAG_ADDR);
            if (commit) begin
                wr_addr <= cap_addr;
                wr_data <= cap_data;
            end
        end
    end

    AST_DRIVE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> $past(rd_act) && !$past(wr_act)); // R4
    AST_NO_WR_IN_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en || flag_wr) |-> !$past(rd_act)); // R9
    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en); // R2
    AST_WR_NOT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (wr_addr != FLAG_ADDR)); // R10
endmodule

// File: rtl/mrp_flags.sv
module mrp_flags #(
    parameter int DW    = 16,
    parameter int MBX_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MBX_W-1:0]    mbx_set,
    input  logic [DW-2-MBX_W:0] sts_in,
    input  logic                clr_en,
    input  logic [MBX_W-1:0]    clr_mask,
    input  logic                clr_err,
    input  logic                clash_pulse,
    output logic [MBX_W-1:0]    mbx_q,
    output logic                err_q,
    output logic [DW-1:0]       flag_word
);
    logic [MBX_W-1:0] mbx_nxt;

    for (genvar b = 0; b < MBX_W; b++) begin : g_bit
        assign mbx_nxt[b] = mbx_set[b] ? 1'b1
                          : (clr_en && clr_mask[b]) ? 1'b0
                          : mbx_q[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mbx_q <= '0;
            err_q <= 1'b0;
        end else begin
            mbx_q <= mbx_nxt;
            if (clash_pulse)          err_q <= 1'b1;
            else if (clr_en && clr_err) err_q <= 1'b0;
        end
    end

    assign flag_word = {err_q, sts_in, mbx_q};

    AST_MBX_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr_en) |-> ((mbx_q & $past(mbx_q)) == $past(mbx_q))); // R7
    AST_MBX_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|$past(mbx_set)) |-> ((mbx_q & $past(mbx_set)) == $past(mbx_set))); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_q) && !($past(clr_en) && $past(clr_err))) |-> err_q); // R9
endmodule

// File: rtl/mcu_regport.sv
module mcu_regport #(
    parameter int            AW          = 4,
    parameter int            DW          = 16,
    parameter int            MBX_W       = 8,
    parameter int            SYNC_STAGES = 2,
    parameter logic [AW-1:0] FLAG_ADDR   = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       host_addr,
    input  logic                host_rd_n,
    input  logic                host_wr_n,
    inout  wire  [DW-1:0]       host_data,
    input  logic [MBX_W-1:0]    mbx_set,
    input  logic [DW-2-MBX_W:0] sts_in,
    output logic [MBX_W-1:0]    mbx_flags,
    output logic                proto_err,
    output logic [AW-1:0]       reg_rd_addr,
    input  logic [DW-1:0]       reg_rd_data,
    output logic                reg_wr_en,
    output logic [AW-1:0]       reg_wr_addr,
    output logic [DW-1:0]       reg_wr_data
);
    logic          rd_act, wr_act;
    logic [AW-1:0] addr_s;
    logic [DW-1:0] data_s;
    logic [DW-1:0] flag_word;
    logic          drive_en;
    logic [DW-1:0] drive_data;
    logic          flag_wr;
    logic          clash_pulse;

    mrp_sync #(.AW(AW), .DW(DW), .STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_n_raw (host_rd_n),
        .wr_n_raw (host_wr_n),
        .addr_raw (host_addr),
        .data_raw (host_data),
        .rd_act   (rd_act),
        .wr_act   (wr_act),
        .addr_s   (addr_s),
        .data_s   (data_s)
    );

    mrp_fsm #(.AW(AW), .DW(DW), .FLAG_ADDR(FLAG_ADDR)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_act      (rd_act),
        .wr_act      (wr_act),
        .addr_s      (addr_s),
        .data_s      (data_s),
        .flag_word   (flag_word),
        .reg_rd_data (reg_rd_data),
        .reg_rd_addr (reg_rd_addr),
        .drive_en    (drive_en),
        .drive_data  (drive_data),
        .reg_wr_en   (reg_wr_en),
        .flag_wr     (flag_wr),
        .wr_addr     (reg_wr_addr),
        .wr_data     (reg_wr_data),
        .clash_pulse (clash_pulse)
    );

    mrp_flags #(.DW(DW), .MBX_W(MBX_W)) i_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .mbx_set     (mbx_set),
        .sts_in      (sts_in),
        .clr_en      (flag_wr),
        .clr_mask    (reg_wr_data[MBX_W-1:0]),
        .clr_err     (reg_wr_data[DW-1]),
        .clash_pulse (clash_pulse),
        .mbx_q       (mbx_flags),
        .err_q       (proto_err),
        .flag_word   (flag_word)
    );

    assign host_data = drive_en ? drive_data : {DW{1'bz}};
endmodule

// File: tb/test_mcu_regport.sv
`timescale 1ns/1ps
module test_mcu_regport;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  host_addr = '0;
    logic        host_rd_n = 1'b1;
    logic        host_wr_n = 1'b1;
    logic        host_oe = 1'b0;
    logic [15:0] host_d = '0;
    wire  [15:0] host_data;
    logic [7:0]  mbx_set = '0;
    logic [6:0]  sts_in = 7'h5A;
    logic [7:0]  mbx_flags;
    logic        proto_err;
    logic [3:0]  reg_rd_addr;
    logic [15:0] reg_rd_data;
    logic        reg_wr_en;
    logic [3:0]  reg_wr_addr;
    logic [15:0] reg_wr_data;

    int checks = 0;
    int fails  = 0;
    int wr_cnt = 0;
    bit done   = 1'b0;
    logic [15:0] model [16];
    logic [15:0] rd;

    always #2.5 clk = ~clk;

    assign host_data = host_oe ? host_d : 16'hzzzz;
    for (genvar p = 0; p < 16; p++) begin : g_pull
        pullup pu (host_data[p]);
    end

    assign reg_rd_data = model[reg_rd_addr];

    mcu_regport i_mcu_regport (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd_n(host_rd_n),
        .host_wr_n(host_wr_n), .host_data(host_data), .mbx_set(mbx_set), .sts_in(sts_in),
        .mbx_flags(mbx_flags), .proto_err(proto_err), .reg_rd_addr(reg_rd_addr),
        .reg_rd_data(reg_rd_data), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data)
    );

    always @(posedge clk) begin
        if (reg_wr_en) begin
            model[reg_wr_addr] <= reg_wr_data;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        host_oe = 1'b1; host_addr = a; host_d = d; host_wr_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        host_wr_n = 1'b1; host_oe = 1'b0;
        repeat (5) @(posedge clk);
    endtask

    task automatic host_read(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_rd_n = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        d = host_data;
        host_rd_n = 1'b1;
        repeat (5) @(posedge clk);
    endtask

    function automatic logic [15:0] pat(input int a);
        return 16'(a * 16'h1111) ^ 16'h0A50;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int wc;
        for (int i = 0; i < 16; i++) model[i] = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 bus released in reset", 32'(host_data), 32'hFFFF);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 mailbox zero", 32'(mbx_flags), 32'h0);
        chk("R1 error zero", 32'(proto_err), 32'h0);
        chk("R1 no write pulse", 32'(wr_cnt), 32'h0);
        chk("R4 bus idle hi-z", 32'(host_data), 32'hFFFF);

        // R2 R3: sweep all non-flag addresses
        for (int a = 0; a < 15; a++) begin
            wc = wr_cnt;
            host_write(4'(a), pat(a));
            chk("R2 one pulse per write", 32'(wr_cnt - wc), 32'd1);
        end
        for (int a = 0; a < 15; a++) begin
            host_read(4'(a), rd);
            chk("R3 readback", 32'(rd), 32'(pat(a)));
        end
        chk("R4 bus released after read", 32'(host_data), 32'hFFFF);

        // R5 flag layout
        host_read(4'hF, rd);
        chk("R5 flag word layout", 32'(rd), 32'({1'b0, 7'h5A, 8'h00}));

        // R6 R7 per-bit set and W1C sweep
        for (int b = 0; b < 8; b++) begin
            @(negedge clk); mbx_set = 8'(1 << b);
            @(negedge clk); mbx_set = '0;
            chk("R6 mbx output set", 32'(mbx_flags), 32'(1 << b));
            host_read(4'hF, rd);
            chk("R6 mbx in flag word", 32'(rd[7:0]), 32'(1 << b));
            wc = wr_cnt;
            host_write(4'hF, 16'(1 << b));
            chk("R7 bit cleared", 32'(mbx_flags), 32'h0);
            chk("R10 no fabric write", 32'(wr_cnt - wc), 32'd0);
        end

        // R7 mixed mask
        @(negedge clk); mbx_set = 8'hC7;
        @(negedge clk); mbx_set = '0;
        host_write(4'hF, 16'h0085);
        chk("R7 zeros keep bits", 32'(mbx_flags), 32'h42);
        host_write(4'hF, 16'h00FF);
        chk("R7 clear rest", 32'(mbx_flags), 32'h0);

        // R8 set and clear in the same cycle
        @(negedge clk);
        host_oe = 1'b1; host_addr = 4'hF; host_d = 16'h0008; host_wr_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        host_wr_n = 1'b1; host_oe = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); mbx_set = 8'h08;
        @(posedge clk);
        @(negedge clk); mbx_set = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 set wins over clear", 32'(mbx_flags), 32'h08);
        host_write(4'hF, 16'h0008);
        chk("R8 later clear works", 32'(mbx_flags), 32'h0);

        // R9 clash
        wc = wr_cnt;
        @(negedge clk);
        host_addr = 4'h3; host_rd_n = 1'b0; host_wr_n = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R4 R9 bus released in clash", 32'(host_data), 32'hFFFF);
        host_rd_n = 1'b1; host_wr_n = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R9 no write on clash", 32'(wr_cnt - wc), 32'd0);
        chk("R9 error output", 32'(proto_err), 32'h1);
        host_read(4'h3, rd);
        chk("R9 target untouched", 32'(rd), 32'(pat(3)));
        host_write(4'hF, 16'h0000);
        chk("R9 error sticky on zero write", 32'(proto_err), 32'h1);
        host_read(4'hF, rd);
        chk("R9 error in flag word", 32'(rd[15]), 32'h1);
        host_write(4'hF, 16'h8000);
        chk("R9 error cleared", 32'(proto_err), 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule